// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Per-Character Realignment

This block receives asynchronous serial characters on a single unsynchronized line. It runs on the system clock and uses a one-cycle enable pulse, `os_tick`, that arrives eight times per bit period. While idle it watches the synchronized line for a falling edge. It then starts a three-bit sub-bit counter and confirms the start bit with a second look on the third tick. Each later bit is sampled on the third tick of its eight-tick window.

A character has a start bit, eight data bits with the least significant bit first, an optional parity bit, and a stop bit. The stop sample completes the character. The receiver returns to idle on the very next clock, whatever value the stop bit had. This lets the next falling edge realign the sub-bit counter to the transmitter, so a rate offset never builds up from one character to the next.

The received byte is held in a single buffer with a full flag. Framing and parity errors are reported for the buffered byte, and an overrun flag records a byte that was dropped. A one-cycle read strobe empties the buffer.

Top module: `uart_rx_resync`

## Requirements
- R1: While reset is applied and after it is released, all flags, `active` and `rx_data` read 0. The internal reset is released two clocks after `rst_n` rises.
- R2: `rxd_async` passes through a two-flop synchronizer. A falling edge seen while idle raises `active` three clock edges after the input changes, without waiting for `os_tick`. The sub-bit counter (0 to 7) advances only on `os_tick` and only while `active` is 1.
- R3: The start bit is checked again on the third `os_tick` after detection, which is counter value 2. If the line is high at that point, the receiver returns to idle: `active` falls and no byte is delivered.
- R4: Each data bit is sampled on the `os_tick` at counter value 2 of its own eight-tick window. The first data bit becomes `rx_data[0]`.
- R5: On the stop sample, `active` falls and the receiver is idle on the next clock, whether the stop bit was 1 or 0.
- R6: `frame_err` is set to the inverse of the sampled stop bit at the stop sample. It is updated only when a byte is loaded into the buffer.
- R7: `full` is set when a byte is loaded at the stop sample. A one-cycle `buf_rd` clears it.
- R8: If a character completes while `full` is 1 and `buf_rd` is 0, then `overrun` is set and the new byte is discarded. In that case `rx_data`, `frame_err` and `par_err` keep their values. `buf_rd` clears `overrun`.
- R9: With `par_en` = 1, a parity bit follows data bit 7. With `par_odd` = 0 the data plus the parity bit hold an even number of ones; with `par_odd` = 1 they hold an odd number. `par_err` is set on a mismatch. With `par_en` = 0 the frame is 10 bits long and `par_err` is 0.
- R10: Characters sent back to back with a bit period 3 percent shorter or longer than eight ticks are all received correctly, because the receiver realigns on each start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Sub-bit enable pulse, eight per bit period |
| rxd_async | input | 1 | Serial line, unsynchronized, idle high |
| par_en | input | 1 | Enables the parity bit; change only while idle |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| buf_rd | input | 1 | One-cycle read strobe for the holding buffer |
| rx_data | output | 8 | Holding buffer contents |
| full | output | 1 | Buffer holds an unread byte |
| active | output | 1 | A character is being received |
| frame_err | output | 1 | Stop bit of the buffered byte was 0 |
| overrun | output | 1 | A byte was dropped because the buffer was full |
| par_err | output | 1 | Parity mismatch on the buffered byte |

## Verification
A sub-bit counter or bit index that is off by one tick shows at the ports within a character. `active` falls at the wrong clock, and `full` then rises at the wrong clock too. A data bit that is sampled one window early or late shifts the value in `rx_data`. If the receiver stays out of idle after the stop sample, the next back-to-back character starts late and is received wrongly or missed. Because the reference model is compared on every clock, any of these faults is reported at the first clock edge where a port differs.

// File: rtl/uart_rx_resync_pkg.sv
`timescale 1ns/1ps
package uart_rx_resync_pkg;
  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_PAR   = 3'd3,
    RX_STOP  = 3'd4
  } rx_state_e;
endpackage

// File: rtl/uart_rx_resync_sync.sv
`timescale 1ns/1ps
module uart_rx_resync_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_resync_fsm.sv
`timescale 1ns/1ps
module uart_rx_resync_fsm
  import uart_rx_resync_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OSR       = 8,
  parameter int SAMPLE_PT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd_s,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] word,
  output logic              stop_ok,
  output logic              par_bad
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              pbit_q, pbit_d;
  logic              rxd_q;
  logic              fall, at_samp, at_wrap;

  assign fall    = rxd_q & ~rxd_s;
  assign at_samp = tick && (cnt_q == CNT_W'(SAMPLE_PT));
  assign at_wrap = tick && (cnt_q == CNT_W'(OSR - 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    pbit_d  = pbit_q;
    done    = 1'b0;
    if (state_q != RX_IDLE && tick)
      cnt_d = at_wrap ? '0 : cnt_q + 1'b1;
    case (state_q)
      RX_IDLE: begin
        if (fall) begin
          state_d = RX_START;
          cnt_d   = '0;
        end
      end
      RX_START: begin
        if (at_samp && rxd_s) state_d = RX_IDLE;
        else if (at_wrap) begin
          state_d = RX_DATA;
          idx_d   = '0;
        end
      end
      RX_DATA: begin
        if (at_samp) sh_d = {rxd_s, sh_q[DATA_W-1:1]};
        if (at_wrap) begin
          if (idx_q == IDX_W'(DATA_W - 1)) state_d = par_en ? RX_PAR : RX_STOP;
          else                             idx_d   = idx_q + 1'b1;
        end
      end
      RX_PAR: begin
        if (at_samp) pbit_d  = rxd_s;
        if (at_wrap) state_d = RX_STOP;
      end
      RX_STOP: begin
        if (at_samp) begin
          done    = 1'b1;
          state_d = RX_IDLE;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
      rxd_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      pbit_q  <= pbit_d;
      rxd_q   <= rxd_s;
    end
  end

  assign busy    = (state_q != RX_IDLE);
  assign word    = sh_q;
  assign stop_ok = rxd_s;
  assign par_bad = par_en & ((^sh_q ^ pbit_q) != par_odd);
endmodule

// File: rtl/uart_rx_resync_hold.sv
`timescale 1ns/1ps
module uart_rx_resync_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] word,
  input  logic              stop_ok,
  input  logic              par_bad,
  input  logic              rd,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              frame_err,
  output logic              overrun,
  output logic              par_err
);
  logic [DATA_W-1:0] data_q, data_d;
  logic full_q, full_d, fe_q, fe_d, ov_q, ov_d, pe_q, pe_d;
  logic still_full, accept, lose;

  assign still_full = full_q & ~rd;
  assign accept     = done & ~still_full;
  assign lose       = done & still_full;

  always_comb begin
    full_d = still_full | accept;
    data_d = accept ? word     : data_q;
    fe_d   = accept ? ~stop_ok : fe_q;
    pe_d   = accept ? par_bad  : pe_q;
    ov_d   = lose | (ov_q & ~rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      fe_q   <= 1'b0;
      ov_q   <= 1'b0;
      pe_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      full_q <= full_d;
      fe_q   <= fe_d;
      ov_q   <= ov_d;
      pe_q   <= pe_d;
    end
  end

  assign data      = data_q;
  assign full      = full_q;
  assign frame_err = fe_q;
  assign overrun   = ov_q;
  assign par_err   = pe_q;
endmodule

// File: rtl/uart_rx_resync.sv
`timescale 1ns/1ps
module uart_rx_resync #(
  parameter int DATA_W    = 8,
  parameter int OSR       = 8,
  parameter int SAMPLE_PT = 2,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd_async,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              buf_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              full,
  output logic              active,
  output logic              frame_err,
  output logic              overrun,
  output logic              par_err
);
  logic              rst_i;
  logic              rxd_s;
  logic              done;
  logic [DATA_W-1:0] word;
  logic              stop_ok;
  logic              par_bad;

  uart_rx_resync_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_i)
  );

  uart_rx_resync_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_rxd_sync (
    .clk(clk), .rst_n(rst_i), .d(rxd_async), .q(rxd_s)
  );

  uart_rx_resync_fsm #(.DATA_W(DATA_W), .OSR(OSR), .SAMPLE_PT(SAMPLE_PT)) u_fsm (
    .clk(clk), .rst_n(rst_i), .tick(os_tick), .rxd_s(rxd_s),
    .par_en(par_en), .par_odd(par_odd), .busy(active), .done(done),
    .word(word), .stop_ok(stop_ok), .par_bad(par_bad)
  );

  uart_rx_resync_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_i), .done(done), .word(word), .stop_ok(stop_ok),
    .par_bad(par_bad), .rd(buf_rd), .data(rx_data), .full(full),
    .frame_err(frame_err), .overrun(overrun), .par_err(par_err)
  );
endmodule

// File: rtl/uart_rx_resync_chk.sv
`timescale 1ns/1ps
module uart_rx_resync_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_i,
  input logic              buf_rd,
  input logic              full,
  input logic              active,
  input logic              overrun,
  input logic              frame_err,
  input logic [DATA_W-1:0] rx_data
);
  // R5
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(full) |-> (!active && $past(active)));

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(overrun) |-> (full && $past(full)));

  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_i)
    buf_rd |=> !overrun);

  // R8
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (full && !buf_rd) |=> $stable(rx_data));

  // R6
  frame_flag_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(frame_err) |-> full);
endmodule

bind uart_rx_resync uart_rx_resync_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_i(rst_i), .buf_rd(buf_rd), .full(full), .active(active),
  .overrun(overrun), .frame_err(frame_err), .rx_data(rx_data)
);

// File: tb/uart_rx_resync_bench.sv
`timescale 1ns/1ps
module uart_rx_resync_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic rxd = 1'b1;
  logic par_en = 1'b0;
  logic par_odd = 1'b0;
  logic buf_rd = 1'b0;
  logic [7:0] rx_data;
  logic full, active, frame_err, overrun, par_err;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  uart_rx_resync u_uart_rx_resync (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd_async(rxd),
    .par_en(par_en), .par_odd(par_odd), .buf_rd(buf_rd), .rx_data(rx_data),
    .full(full), .active(active), .frame_err(frame_err), .overrun(overrun),
    .par_err(par_err)
  );

  // tick generator: one pulse every 4 clocks, 32 clocks per bit
  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      os_tick = (div == 3);
      div = (div + 1) % 4;
    end
  end

  // ---------------- reference model ----------------
  int r1, r2, s1, s2, prv;
  int ph, cnt, bidx, pb;
  logic [7:0] sh;
  int m_full, m_fe, m_ov, m_pe;
  logic [7:0] m_data;

  task automatic model_clear();
    s1 = 1; s2 = 1; prv = 1; ph = 0; cnt = 0; bidx = 0; pb = 0; sh = '0;
    m_full = 0; m_fe = 0; m_ov = 0; m_pe = 0; m_data = '0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1 = 0; r2 = 0;
      model_clear();
    end else begin
      int old_r;
      old_r = r2; r2 = r1; r1 = 1;
      if (old_r == 0) model_clear();
      else begin
        int fin, stv, samp, wrap, keep;
        fin = 0; stv = 0;
        if (ph == 0) begin
          if (prv == 1 && s2 == 0) begin ph = 1; cnt = 0; end
        end else if (os_tick) begin
          samp = (cnt == 2);
          wrap = (cnt == 7);
          cnt = (cnt + 1) % 8;
          case (ph)
            1: if (samp && s2 == 1) ph = 0;
               else if (wrap) begin ph = 2; bidx = 0; end
            2: begin
                 if (samp) sh = {s2[0], sh[7:1]};
                 if (wrap) begin
                   if (bidx == 7) ph = par_en ? 3 : 4;
                   else bidx++;
                 end
               end
            3: begin
                 if (samp) pb = s2;
                 if (wrap) ph = 4;
               end
            default: if (samp) begin fin = 1; stv = s2; ph = 0; end
          endcase
        end
        keep = m_full && !buf_rd;
        if (buf_rd) m_ov = 0;
        if (fin && keep) m_ov = 1;
        if (fin && !keep) begin
          m_data = sh;
          m_fe = (stv == 0);
          m_pe = par_en && ((($countones(sh) % 2) ^ pb) != int'(par_odd));
        end
        m_full = keep || fin;
        prv = s2; s2 = s1; s1 = rxd;
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    chk("R2 active vs model", active, (ph != 0));
    chk("R4 rx_data vs model", rx_data, m_data);
    chk("R7 full vs model", full, m_full);
    chk("R6 frame_err vs model", frame_err, m_fe);
    chk("R8 overrun vs model", overrun, m_ov);
    chk("R9 par_err vs model", par_err, m_pe);
  end

  // ---------------- stimulus helpers ----------------
  task automatic send_bit(input logic b, input int n);
    rxd = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int n, input logic pe,
                            input logic podd, input logic pflip, input logic stopv);
    send_bit(1'b0, n);
    for (int i = 0; i < 8; i++) send_bit(d[i], n);
    if (pe) send_bit((^d) ^ podd ^ pflip, n);
    send_bit(stopv, n);
    rxd = 1'b1;
  endtask

  task automatic read_buf();
    buf_rd = 1'b1;
    @(negedge clk);
    buf_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [7:0] got_q[$];
  logic [7:0] exp_b2b[6] = '{8'hC3, 8'h00, 8'hFF, 8'h96, 8'h01, 8'h80};

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk("R1 full", full, 0);
    chk("R1 active", active, 0);
    chk("R1 frame_err", frame_err, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 par_err", par_err, 0);
    chk("R1 rx_data", rx_data, 0);
    idle(20);

    // R2 detection latency, R4 data, R5 idle after stop
    fork
      send_frame(8'h3C, 32, 1'b0, 1'b0, 1'b0, 1'b1);
      begin
        idle(2);
        chk("R2 active before edge reaches detector", active, 0);
        idle(1);
        chk("R2 active after detection", active, 1);
      end
    join
    idle(4);
    chk("R4 byte 3C", rx_data, 8'h3C);
    chk("R7 full set", full, 1);
    chk("R5 idle after stop", active, 0);
    chk("R6 no framing error", frame_err, 0);
    read_buf();
    chk("R7 full cleared by read", full, 0);

    // R3 false start
    send_bit(1'b0, 6);
    rxd = 1'b1;
    idle(60);
    chk("R3 false start back to idle", active, 0);
    chk("R3 false start gives no byte", full, 0);

    // R6 framing error and recovery
    send_frame(8'h81, 32, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(8);
    chk("R6 framing error set", frame_err, 1);
    chk("R6 byte still delivered", rx_data, 8'h81);
    chk("R5 idle after low stop", active, 0);
    read_buf();
    send_frame(8'h55, 32, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(8);
    chk("R6 framing error cleared on next byte", frame_err, 0);
    chk("R4 byte 55", rx_data, 8'h55);
    read_buf();

    // R8 overrun
    send_frame(8'h11, 32, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(8);
    send_frame(8'h22, 32, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(8);
    chk("R8 overrun set", overrun, 1);
    chk("R8 first byte kept", rx_data, 8'h11);
    chk("R8 frame_err of kept byte", frame_err, 0);
    read_buf();
    chk("R8 overrun cleared", overrun, 0);
    chk("R8 full cleared", full, 0);

    // R9 parity
    par_en = 1'b1; par_odd = 1'b0;
    send_frame(8'h5A, 32, 1'b1, 1'b0, 1'b0, 1'b1);
    idle(8);
    chk("R9 even parity good", par_err, 0);
    chk("R9 even data", rx_data, 8'h5A);
    read_buf();
    send_frame(8'h5B, 32, 1'b1, 1'b0, 1'b1, 1'b1);
    idle(8);
    chk("R9 even parity bad", par_err, 1);
    chk("R9 stop still good", frame_err, 0);
    read_buf();
    par_odd = 1'b1;
    send_frame(8'h07, 32, 1'b1, 1'b1, 1'b0, 1'b1);
    idle(8);
    chk("R9 odd parity good", par_err, 0);
    read_buf();
    send_frame(8'hE4, 32, 1'b1, 1'b1, 1'b1, 1'b1);
    idle(8);
    chk("R9 odd parity bad", par_err, 1);
    chk("R9 odd data", rx_data, 8'hE4);
    read_buf();
    par_en = 1'b0; par_odd = 1'b0;
    idle(10);

    // R10 back to back with rate offset
    fork
      begin
        for (int k = 0; k < 3; k++) send_frame(exp_b2b[k], 31, 1'b0, 1'b0, 1'b0, 1'b1);
        for (int k = 3; k < 6; k++) send_frame(exp_b2b[k], 33, 1'b0, 1'b0, 1'b0, 1'b1);
      end
      begin
        for (int k = 0; k < 6; k++) begin
          do @(negedge clk); while (!full);
          got_q.push_back(rx_data);
          read_buf();
        end
      end
    join
    for (int k = 0; k < 6; k++) chk("R10 back-to-back byte", got_q[k], exp_b2b[k]);
    chk("R10 no overrun", overrun, 0);
    chk("R10 no framing error", frame_err, 0);
    idle(10);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule